// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator for a Random Number Source

This block gathers the interrupt sources of a random number peripheral and presents them on one interrupt line. The lower level holds three sticky flags: generation done, deterministic-test fault and entropy-test fault. Each flag has its own enable. The OR of the enabled flags forms a single core-interrupt bit. The upper level holds a two-bit status (the core-interrupt bit and a bus slave-error bit) and a two-bit mask. The mask can only be changed through a pair of write-only set and clear addresses.

Software reaches the block through a simple register port: a write strobe, a word address, write data, and read data driven combinationally from the address. The generator logic sends single-cycle event pulses. Fault pulses are only accepted while the entropy source is running. On older silicon revisions, an entropy-test fault also needs the online-test enable.

Top module: `trng_irq_agg`

## Requirements
- R1: After synchronous reset, the enables, flags and status are all 0, the mask reads 0x3, and irq is 0.
- R2: A pulse on ev_done sets the done flag (flags register bit 0) with no gating. The flag stays set until it is explicitly cleared.
- R3: Pulses on ev_dtest (flags bit 1) and ev_etest (flags bit 3) are ignored while src_rst is 1, src_en is 0 or osc_en is 0.
- R4: While legacy_rev is 1 and ontest_en is 0, ev_etest is ignored even if the source is running.
- R5: A write to word address 0 stores wdata[2:0] as the enables for done, deterministic fault and entropy fault, in that order. A 1 in wdata[3], wdata[4] or wdata[5] clears the matching flag, in the same order. An event in the same cycle wins over the clear. Address 0 reads back only the enables.
- R6: On any core update (a write to address 0 or an accepted event), status bit 0 becomes the OR over the flags of (flag AND enable), using the updated values.
- R7: Status (address 2) is write-1-to-clear on bits [1:0]. Bit 1 is set by ev_slverr, and the set wins over a clear in the same cycle. A clear of bit 0 holds until the next core update.
- R8: The mask (address 3) is read-only. Writing 1s to address 4 clears those mask bits. Writing 1s to address 5 sets them. Addresses 4 and 5 read as 0.
- R9: irq is a register. After each clock edge it equals the OR over the status bits of (status AND NOT mask).
- R10: Word address map: 0 enable/clear, 1 flags (done bit 0, deterministic fault bit 1, entropy fault bit 3), 2 status, 3 mask, 4 mask clear, 5 mask set. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| ev_done | input | 1 | Generation done pulse |
| ev_dtest | input | 1 | Deterministic-test fault pulse |
| ev_etest | input | 1 | Entropy-test fault pulse |
| ev_slverr | input | 1 | Bus slave-error pulse |
| src_rst | input | 1 | Entropy source held in reset |
| src_en | input | 1 | Entropy source enabled |
| osc_en | input | 1 | Oscillator enabled |
| ontest_en | input | 1 | Online health test enabled |
| legacy_rev | input | 1 | Older silicon revision |
| irq | output | 1 | Interrupt line |

## Verification
The bench sends fault pulses under each combination of source-inactive conditions, and under the legacy revision without the online test. A design with missing gating would set a fault flag and raise irq when it should not. It clears status bit 0 while the enabled flags are still set, and checks that the bit stays low until the next core write. A design that ties that bit to the level of the flags would raise irq again at once. It also applies an event together with a clear of the same flag, and a slave error together with its write-1-to-clear, where the wrong priority would lose an interrupt. Finally it writes directly to the mask address, which must leave the mask unchanged.

// File: rtl/trng_irq_pkg.sv
package trng_irq_pkg;
  localparam int NFLAG = 3;
  localparam int NSTAT = 2;
  // flag index order: 0 done, 1 deterministic fault, 2 entropy fault
  localparam logic [NFLAG-1:0] GATED_FLAGS  = 3'b110;
  localparam logic [NFLAG-1:0] ONTEST_FLAGS = 3'b100;
  localparam int FLAG_POS [NFLAG] = '{0, 1, 3};

  typedef enum logic [2:0] {
    A_CORE_EN = 3'd0,
    A_FLAGS   = 3'd1,
    A_STAT    = 3'd2,
    A_MASK    = 3'd3,
    A_MSK_CLR = 3'd4,
    A_MSK_SET = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_evt_gate.sv
module irq_evt_gate #(
  parameter int NF = 3,
  parameter logic [NF-1:0] GATED  = '0,
  parameter logic [NF-1:0] ONTEST = '0
) (
  input  logic [NF-1:0] ev,
  input  logic          src_rst,
  input  logic          src_en,
  input  logic          osc_en,
  input  logic          ontest_en,
  input  logic          legacy_rev,
  output logic [NF-1:0] set_req
);
  logic running;
  logic ontest_ok;
  assign running   = !src_rst && src_en && osc_en;
  assign ontest_ok = !legacy_rev || ontest_en;

  for (genvar i = 0; i < NF; i++) begin : g_gate
    if (GATED[i] && ONTEST[i]) begin : g_both
      assign set_req[i] = ev[i] && running && ontest_ok;
    end else if (GATED[i]) begin : g_run
      assign set_req[i] = ev[i] && running;
    end else begin : g_free
      assign set_req[i] = ev[i];
    end
  end
endmodule

// File: rtl/irq_core_flags.sv
module irq_core_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [2*NF-1:0] wdata,
  input  logic [NF-1:0] set_req,
  output logic [NF-1:0] en_q,
  output logic [NF-1:0] flag_q,
  output logic          upd,
  output logic          cint_nxt
);
  logic [NF-1:0] en_d;
  logic [NF-1:0] flag_d;

  assign en_d = wr ? wdata[NF-1:0] : en_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flag_d[i] = set_req[i] || (flag_q[i] && !(wr && wdata[NF+i]));
  end

  assign upd      = wr || (|set_req);
  assign cint_nxt = |(flag_d & en_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[NF] && !set_req[0]) |=> !flag_q[0]);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && !(wr && wdata[NF])) |=> flag_q[0]);
endmodule

// File: rtl/irq_top_stage.sv
module irq_top_stage #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_upd,
  input  logic          core_int,
  input  logic          slv_set,
  input  logic          w1c_wr,
  input  logic          ena_wr,
  input  logic          dis_wr,
  input  logic [NS-1:0] wbits,
  output logic [NS-1:0] stat_q,
  output logic [NS-1:0] mask_q,
  output logic          irq_q
);
  logic [NS-1:0] stat_d;
  logic [NS-1:0] mask_d;
  logic [NS-1:0] clr;

  assign clr       = w1c_wr ? wbits : '0;
  assign stat_d[0] = core_upd ? core_int : (stat_q[0] && !clr[0]);
  assign stat_d[1] = slv_set || (stat_q[1] && !clr[1]);

  always_comb begin
    mask_d = mask_q;
    if (ena_wr)      mask_d = mask_q & ~wbits;
    else if (dis_wr) mask_d = mask_q | wbits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & ~mask_d);
    end
  end

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(ena_wr || dis_wr) |=> $stable(mask_q));
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & ~mask_q));
  assert_slv_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (w1c_wr && wbits[1] && !slv_set) |=> !stat_q[1]);
endmodule

// File: rtl/trng_irq_agg.sv
module trng_irq_agg
  import trng_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_done,
  input  logic              ev_dtest,
  input  logic              ev_etest,
  input  logic              ev_slverr,
  input  logic              src_rst,
  input  logic              src_en,
  input  logic              osc_en,
  input  logic              ontest_en,
  input  logic              legacy_rev,
  output logic              irq
);
  localparam int FW = FLAG_POS[NFLAG-1] + 1;

  logic [NFLAG-1:0] set_req;
  logic [NFLAG-1:0] en_q;
  logic [NFLAG-1:0] flag_q;
  logic [NSTAT-1:0] stat_q;
  logic [NSTAT-1:0] mask_q;
  logic [FW-1:0]    flag_view;
  logic             core_upd;
  logic             cint_nxt;
  logic             wr_core;
  logic             wr_stat;
  logic             wr_mclr;
  logic             wr_mset;

  assign wr_core = reg_wr && (reg_addr == ADDR_W'(A_CORE_EN));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign wr_mclr = reg_wr && (reg_addr == ADDR_W'(A_MSK_CLR));
  assign wr_mset = reg_wr && (reg_addr == ADDR_W'(A_MSK_SET));

  irq_evt_gate #(.NF(NFLAG), .GATED(GATED_FLAGS), .ONTEST(ONTEST_FLAGS)) u_gate (
    .ev        ({ev_etest, ev_dtest, ev_done}),
    .src_rst   (src_rst),
    .src_en    (src_en),
    .osc_en    (osc_en),
    .ontest_en (ontest_en),
    .legacy_rev(legacy_rev),
    .set_req   (set_req)
  );

  irq_core_flags #(.NF(NFLAG)) u_core (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_core),
    .wdata   (reg_wdata[2*NFLAG-1:0]),
    .set_req (set_req),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .upd     (core_upd),
    .cint_nxt(cint_nxt)
  );

  irq_top_stage #(.NS(NSTAT)) u_top (
    .clk     (clk),
    .rst     (rst),
    .core_upd(core_upd),
    .core_int(cint_nxt),
    .slv_set (ev_slverr),
    .w1c_wr  (wr_stat),
    .ena_wr  (wr_mclr),
    .dis_wr  (wr_mset),
    .wbits   (reg_wdata[NSTAT-1:0]),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq_q   (irq)
  );

  always_comb begin
    flag_view = '0;
    for (int i = 0; i < NFLAG; i++) flag_view[FLAG_POS[i]] = flag_q[i];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CORE_EN): reg_rdata[NFLAG-1:0] = en_q;
      ADDR_W'(A_FLAGS):   reg_rdata[FW-1:0]    = flag_view;
      ADDR_W'(A_STAT):    reg_rdata[NSTAT-1:0] = stat_q;
      ADDR_W'(A_MASK):    reg_rdata[NSTAT-1:0] = mask_q;
      default:            reg_rdata = '0;
    endcase
  end

  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (src_rst || !src_en || !osc_en) |=> !$rose(flag_q[1]) && !$rose(flag_q[2]));
  assert_ontest_R4: assert property (@(posedge clk) disable iff (rst)
    (legacy_rev && !ontest_en) |=> !$rose(flag_q[2]));
  assert_core_int_R6: assert property (@(posedge clk) disable iff (rst)
    wr_core |=> stat_q[0] == |(flag_q & en_q));
endmodule

// File: tb/tb_trng_irq_agg.sv
module tb_trng_irq_agg;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic ev_done = 0, ev_dtest = 0, ev_etest = 0, ev_slverr = 0;
  logic src_rst = 1, src_en = 0, osc_en = 0, ontest_en = 0, legacy_rev = 0;
  logic irq;

  int total = 0;
  int bad = 0;

  // behavioural model state
  bit [2:0] m_en;
  bit m_done, m_dt, m_et;
  bit [1:0] m_stat;
  bit [1:0] m_mask;
  bit m_irq;

  always #5 clk = ~clk;

  trng_irq_agg dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_dtest(ev_dtest), .ev_etest(ev_etest),
    .ev_slverr(ev_slverr), .src_rst(src_rst), .src_en(src_en),
    .osc_en(osc_en), .ontest_en(ontest_en), .legacy_rev(legacy_rev),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_done = 0; m_dt = 0; m_et = 0;
      m_stat = 0; m_mask = 2'b11; m_irq = 0;
    end else begin
      bit act, upd;
      act = !src_rst && src_en && osc_en;
      upd = 0;
      if (reg_wr && reg_addr == 0) begin
        m_en = reg_wdata[2:0];
        if (reg_wdata[3]) m_done = 0;
        if (reg_wdata[4]) m_dt = 0;
        if (reg_wdata[5]) m_et = 0;
        upd = 1;
      end
      if (ev_done) begin m_done = 1; upd = 1; end
      if (ev_dtest && act) begin m_dt = 1; upd = 1; end
      if (ev_etest && act && (!legacy_rev || ontest_en)) begin m_et = 1; upd = 1; end
      if (upd)
        m_stat[0] = (m_done && m_en[0]) || (m_dt && m_en[1]) || (m_et && m_en[2]);
      else if (reg_wr && reg_addr == 2 && reg_wdata[0])
        m_stat[0] = 0;
      if (ev_slverr) m_stat[1] = 1;
      else if (reg_wr && reg_addr == 2 && reg_wdata[1]) m_stat[1] = 0;
      if (reg_wr && reg_addr == 4) m_mask = m_mask & ~reg_wdata[1:0];
      if (reg_wr && reg_addr == 5) m_mask = m_mask | reg_wdata[1:0];
      m_irq = |(m_stat & ~m_mask);
    end
  end

  // R9: irq compared with the model on every cycle
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R9 irq actual=%0b expected=%0b at %0t", irq, m_irq, $time);
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_en};
      3'd1: return {28'd0, m_et, 1'b0, m_dt, m_done};
      3'd2: return {30'd0, m_stat};
      3'd3: return {30'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d,
                     input logic [3:0] ev);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    {ev_slverr, ev_etest, ev_dtest, ev_done} = ev;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    {ev_slverr, ev_etest, ev_dtest, ev_done} = 4'b0;
  endtask

  task automatic chk(input logic [2:0] a, input string tag);
    logic [31:0] e;
    reg_addr = a;
    #1;
    e = exp_read(a);
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 8; a++) chk(3'(a), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_all("R1 reset");
    total++;
    if (irq !== 1'b0) begin bad++; $display("FAIL R1 irq actual=%0b expected=0", irq); end

    // R8: direct write to mask is ignored
    cyc(1, 3'd3, 32'h0, 4'b0); chk(3'd3, "R8 mask read-only");
    // R2: done with enable off
    cyc(0, 3'd0, 0, 4'b0001); chk(3'd1, "R2 done set"); chk(3'd2, "R6 no enable");
    cyc(0, 3'd0, 0, 4'b0000); chk(3'd1, "R2 done sticky");
    // R6: enable done -> core bit
    cyc(1, 3'd0, 32'h1, 4'b0); chk(3'd2, "R6 core int"); chk(3'd0, "R5 enable readback");
    // R8: unmask core bit
    cyc(1, 3'd4, 32'h1, 4'b0); chk(3'd3, "R8 mask clear"); chk(3'd4, "R8 clr reads 0");
    // R5: clear done flag
    cyc(1, 3'd0, 32'h9, 4'b0); chk(3'd1, "R5 clear"); chk(3'd2, "R6 after clear");
    chk(3'd0, "R5 clear bits read 0");
    // R3: faults gated
    cyc(1, 3'd0, 32'h7, 4'b0);
    src_rst = 1; src_en = 1; osc_en = 1;
    cyc(0, 3'd0, 0, 4'b0110); chk(3'd1, "R3 in reset");
    src_rst = 0; src_en = 0;
    cyc(0, 3'd0, 0, 4'b0110); chk(3'd1, "R3 source off");
    src_en = 1; osc_en = 0;
    cyc(0, 3'd0, 0, 4'b0110); chk(3'd1, "R3 osc off");
    osc_en = 1;
    cyc(0, 3'd0, 0, 4'b0010); chk(3'd1, "R3 dtest accepted"); chk(3'd2, "R6 dtest");
    // R4: legacy entropy gating
    legacy_rev = 1;
    cyc(0, 3'd0, 0, 4'b0100); chk(3'd1, "R4 ontest off");
    ontest_en = 1;
    cyc(0, 3'd0, 0, 4'b0100); chk(3'd1, "R4 ontest on");
    // R7: w1c of core bit holds until next core update
    cyc(1, 3'd2, 32'h1, 4'b0); chk(3'd2, "R7 w1c core bit");
    cyc(0, 3'd0, 0, 4'b0); chk(3'd2, "R7 core bit stays clear");
    cyc(1, 3'd0, 32'h7, 4'b0); chk(3'd2, "R6 recomputed");
    // R7: slave error and priority
    cyc(1, 3'd4, 32'h2, 4'b1000); chk(3'd2, "R7 slverr set");
    cyc(1, 3'd2, 32'h2, 4'b1000); chk(3'd2, "R7 set beats clear");
    cyc(1, 3'd2, 32'h2, 4'b0000); chk(3'd2, "R7 slverr cleared");
    // R8: mask set via disable address
    cyc(1, 3'd5, 32'h3, 4'b0); chk(3'd3, "R8 mask set"); chk(3'd5, "R8 set reads 0");
    // R5: event beats clear in same cycle
    cyc(1, 3'd0, 32'h3F, 4'b0001); chk(3'd1, "R5 event wins"); chk(3'd0, "R5 enables");
    cyc(1, 3'd4, 32'h3, 4'b0); chk(3'd3, "R8 unmask all");
    cyc(1, 3'd0, 32'h08, 4'b0); chk(3'd2, "R6 all disabled");
    chk(3'd6, "R10 unused address"); chk(3'd7, "R10 unused address");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule